// File: doc/BRIEF.md
# Snoopable Store Queue with DMA Conflict Cancellation

This block holds CPU stores that have been accepted but not yet written to memory, and hands them to the memory side strictly in acceptance order. A device that wants to write memory directly must first raise a request carrying its target address. The queue compares the cache line of that address against every pending store at once and discards every pending store to the same line. Because those stores are discarded, a stale CPU value can never land on top of the device's newer data.

While the request is being resolved, the device is told to hold and the queue stops presenting stores to memory. Once the conflicting stores are gone, the queue returns a single-cycle acknowledgement, and the device may then complete its write. Discarded stores keep their slot until the drain pointer reaches them. The drain pointer steps over them without emitting anything and frees the slot.

Top module: `wbuf_snoop`

## Requirements
- R1: After reset, st_ready is 1 and drain_valid, dma_ack and dma_hold are 0.
- R2: A store is accepted on a rising edge where st_valid and st_ready are both 1. Stores that are not cancelled leave on drain_addr/drain_data in acceptance order, each exactly once, on an edge where drain_valid and drain_ready are both 1. An offered store stays stable until it is taken or a device request arrives.
- R3: With DEPTH (8) slots occupied, st_ready is 0 and st_valid is ignored: no store is taken while st_ready is low.
- R4: The edge on which dma_req is first seen high with no probe in progress accepts the probe. dma_ack is 1 for exactly the following cycle. A request held high afterwards produces no second acknowledgement until it has been dropped.
- R5: At the acceptance edge, every pending store whose line address (bits AW-1 down to 6, for 64-byte lines) equals that of dma_addr is cancelled, however many there are, and it never appears at the drain port.
- R6: Pending stores to other lines are unaffected by a probe and still drain in order.
- R7: drain_valid is 0 in every cycle where dma_req or dma_ack is 1.
- R8: A cancelled store is skipped by the drain without any drain_valid pulse, and its slot is freed: after the queue empties, st_ready returns to 1.
- R9: A store accepted on the same edge as a probe counts as newer than the device write and is not cancelled, even if it targets the same line.
- R10: dma_hold is 1 while dma_req is 1 and dma_ack has not yet been given for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | CPU store offered |
| st_ready | output | 1 | A free slot exists |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| drain_valid | output | 1 | Head store offered to memory |
| drain_ready | input | 1 | Memory takes the head store |
| drain_addr | output | AW | Head store address |
| drain_data | output | DW | Head store data |
| dma_req | input | 1 | Device write waiting for clearance |
| dma_addr | input | AW | Device write byte address |
| dma_hold | output | 1 | Device write must wait |
| dma_ack | output | 1 | Conflicts resolved, device write may proceed |

## Verification
The properties assume the device keeps dma_req high from the first cycle until it sees dma_ack. A request that stays high past that point is tolerated, but only as one held request. The stimulus raises a request only when no probe is open, drops it on the cycle after the acknowledgement (except in one directed case that deliberately holds it longer), and picks store and probe addresses from a handful of lines so that conflicts are frequent. Memory back-pressure on drain_ready is random, so the stability property on an offered store sees many stalled cycles.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACK  = 2'd1,
    PH_HOLD = 2'd2
  } probe_ph_t;
endpackage

// File: rtl/wbuf_tagcam.sv
// Address storage with one comparator per slot; line match ignores the
// byte offset bits.
module wbuf_tagcam #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int LOFF  = 6,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PW-1:0]    rd_idx,
  output logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    probe_addr,
  output logic [DEPTH-1:0] hit
);
  logic [AW-1:0] addr_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PW'(i))) addr_q[i] <= wr_addr;
    end
    assign hit[i] = ((addr_q[i] >> LOFF) == (probe_addr >> LOFF));
  end

  assign rd_addr = addr_q[rd_idx];
endmodule

// File: rtl/wbuf_dataram.sv
// Data payload store: one write port, one asynchronous read port.
module wbuf_dataram #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wbuf_probe_fsm.sv
// Sequencer for device probes: accept, acknowledge one cycle later, then
// wait for the request to drop.
module wbuf_probe_fsm
  import wbuf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dma_req,
  output logic cancel_go,
  output logic busy,
  output logic ack
);
  probe_ph_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (dma_req)  ph_d = PH_ACK;
      PH_ACK:  ph_d = dma_req ? PH_HOLD : PH_IDLE;
      PH_HOLD: if (!dma_req) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_IDLE;
    else     ph_q <= ph_d;
  end

  assign cancel_go = (ph_q == PH_IDLE) && dma_req;
  assign busy      = dma_req || (ph_q != PH_IDLE);
  assign ack       = (ph_q == PH_ACK);
endmodule

// File: rtl/wbuf_snoop.sv
module wbuf_snoop #(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          drain_valid,
  input  logic          drain_ready,
  output logic [AW-1:0] drain_addr,
  output logic [DW-1:0] drain_data,
  input  logic          dma_req,
  input  logic [AW-1:0] dma_addr,
  output logic          dma_hold,
  output logic          dma_ack
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LOFF = $clog2(LINE_BYTES);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0] occ_q, occ_d;   // slot allocated
  logic [DEPTH-1:0] live_q, live_d; // slot allocated and not cancelled
  logic [PW-1:0]    head_q, tail_q;
  logic [DEPTH-1:0] hit, kill;
  logic             cancel_go, busy, ack;
  logic             push, pop, skip;

  wbuf_probe_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .dma_req   (dma_req),
    .cancel_go (cancel_go),
    .busy      (busy),
    .ack       (ack)
  );

  wbuf_tagcam #(.DEPTH(DEPTH), .AW(AW), .LOFF(LOFF)) u_cam (
    .clk        (clk),
    .wr_en      (push),
    .wr_idx     (tail_q),
    .wr_addr    (st_addr),
    .rd_idx     (head_q),
    .rd_addr    (drain_addr),
    .probe_addr (dma_addr),
    .hit        (hit)
  );

  wbuf_dataram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (tail_q),
    .wdata (st_data),
    .raddr (head_q),
    .rdata (drain_data)
  );

  assign st_ready    = !occ_q[tail_q];
  assign push        = st_valid && st_ready;
  assign drain_valid = occ_q[head_q] && live_q[head_q] && !busy;
  assign skip        = occ_q[head_q] && !live_q[head_q] && !busy;
  assign pop         = (drain_valid && drain_ready) || skip;
  assign kill        = cancel_go ? (hit & live_q) : '0;
  assign dma_ack     = ack;
  assign dma_hold    = dma_req && !ack;

  always_comb begin
    occ_d  = occ_q;
    live_d = live_q & ~kill;
    if (pop) begin
      occ_d[head_q]  = 1'b0;
      live_d[head_q] = 1'b0;
    end
    if (push) begin
      occ_d[tail_q]  = 1'b1;
      live_d[tail_q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q  <= '0;
      live_q <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      occ_q  <= occ_d;
      live_q <= live_d;
      if (pop)  head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
      if (push) tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_snoop_chk.sv
module wbuf_snoop_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          st_valid,
  input logic          st_ready,
  input logic          drain_valid,
  input logic          drain_ready,
  input logic [AW-1:0] drain_addr,
  input logic [DW-1:0] drain_data,
  input logic          dma_req,
  input logic          dma_hold,
  input logic          dma_ack
);
  p_offer_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (drain_valid && !drain_ready) |=>
      (dma_req || (drain_valid && $stable(drain_addr) && $stable(drain_data))));

  p_full_only_after_push_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(st_ready) |-> $past(st_valid));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    dma_ack |=> !dma_ack);

  p_ack_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
    dma_ack |-> ($past(dma_req) && !$past(dma_ack)));

  p_drain_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (dma_req || dma_ack) |-> !drain_valid);

  p_new_req_held_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> dma_hold);
endmodule

bind wbuf_snoop wbuf_snoop_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .drain_valid (drain_valid),
  .drain_ready (drain_ready),
  .drain_addr  (drain_addr),
  .drain_data  (drain_data),
  .dma_req     (dma_req),
  .dma_hold    (dma_hold),
  .dma_ack     (dma_ack)
);

// File: tb/sim_wbuf_snoop.sv
module sim_wbuf_snoop;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_valid = 1'b0, drain_ready = 1'b0, dma_req = 1'b0;
  logic [AW-1:0] st_addr = '0, dma_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, drain_valid, dma_hold, dma_ack;
  logic [AW-1:0] drain_addr;
  logic [DW-1:0] drain_data;

  int checks = 0, fails = 0;
  int mq_n = 0;
  logic [AW-1:0] mq_a [64];
  logic [DW-1:0] mq_d [64];
  int ph = 0; // 0 idle, 1 ack, 2 hold (expected probe state)
  logic exp_ack = 1'b0;
  int drains_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbuf_snoop #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LINE_BYTES(64)) u0 (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_addr(drain_addr), .drain_data(drain_data),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_hold(dma_hold), .dma_ack(dma_ack)
  );

  function automatic logic [AW-1:0] mk(int line, int off);
    return 32'h1000_0000 + AW'(line * 64 + (off % 64));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: sample after inputs settle, update model, advance to next negedge
  task automatic step();
    bit start;
    #1;
    chk(dma_ack === exp_ack, "R4 ack timing", 64'(dma_ack), 64'(exp_ack));
    if (dma_req || dma_ack) chk(drain_valid === 1'b0, "R7 drain paused", 64'(drain_valid), 0);
    if (drain_valid && drain_ready) begin
      drains_seen++;
      if (mq_n == 0) chk(1'b0, "R5 unexpected drain (cancelled or absent)", 64'(drain_addr), 0);
      else begin
        chk(drain_addr === mq_a[0] && drain_data === mq_d[0], "R2/R6 drain order",
            {drain_addr, drain_data}, {mq_a[0], mq_d[0]});
        for (int i = 1; i < mq_n; i++) begin mq_a[i-1] = mq_a[i]; mq_d[i-1] = mq_d[i]; end
        mq_n--;
      end
    end
    start = dma_req && (ph == 0);
    if (start) begin
      int k;
      chk(dma_hold === 1'b1, "R10 hold on new request", 64'(dma_hold), 1);
      k = 0;
      for (int i = 0; i < mq_n; i++)
        if ((mq_a[i] >> 6) != (dma_addr >> 6)) begin
          mq_a[k] = mq_a[i]; mq_d[k] = mq_d[i]; k++;
        end
      mq_n = k; // R5: all same-line entries removed
    end
    if (st_valid && st_ready) begin // R9: pushed after the cancel
      mq_a[mq_n] = st_addr; mq_d[mq_n] = st_data; mq_n++;
    end
    case (ph)
      0: ph = dma_req ? 1 : 0;
      1: ph = dma_req ? 2 : 0;
      default: ph = dma_req ? 2 : 0;
    endcase
    exp_ack = (ph == 1);
    @(negedge clk);
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    step();
    st_valid = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] a);
    dma_req = 1'b1; dma_addr = a;
    step();
    step();
    dma_req = 1'b0;
  endtask

  task automatic drain_all(input int n);
    drain_ready = 1'b1;
    repeat (n) step();
    drain_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(st_ready === 1'b1, "R1 reset st_ready", 64'(st_ready), 1);
    chk(drain_valid === 1'b0 && dma_ack === 1'b0 && dma_hold === 1'b0, "R1 reset outputs",
        {61'b0, drain_valid, dma_ack, dma_hold}, 0);
    @(negedge clk);

    // R3: fill, then offer a ninth store while full
    for (int i = 0; i < DEPTH; i++) push(mk(i, 4), DW'(32'hA0 + i));
    #1 chk(st_ready === 1'b0, "R3 full", 64'(st_ready), 0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = mk(9, 0); st_data = 32'hDEAD;
    step(); step();
    st_valid = 1'b0;
    drains_seen = 0;
    drain_all(12);
    chk(drains_seen == DEPTH, "R3 ninth store ignored", 64'(drains_seen), DEPTH);
    chk(mq_n == 0, "R2 all drained", 64'(mq_n), 0);

    // R5/R6: multiple same-line entries cancelled, others kept
    push(mk(1, 0), 32'h11); push(mk(2, 8), 32'h22);
    push(mk(1, 60), 32'h33); push(mk(3, 0), 32'h44);
    probe(mk(1, 20));
    drains_seen = 0;
    drain_all(8);
    chk(drains_seen == 2, "R5 two survivors drained", 64'(drains_seen), 2);

    // R8: full queue entirely cancelled, slots come back
    for (int i = 0; i < DEPTH; i++) push(mk(5, i * 4), DW'(i));
    probe(mk(5, 63));
    drains_seen = 0;
    drain_all(10);
    chk(drains_seen == 0, "R8 no drain of cancelled", 64'(drains_seen), 0);
    #1 chk(st_ready === 1'b1, "R8 slots freed", 64'(st_ready), 1);
    @(negedge clk);

    // R9: store on the probe edge to the same line survives
    push(mk(6, 0), 32'h60);
    dma_req = 1'b1; dma_addr = mk(6, 8);
    st_valid = 1'b1; st_addr = mk(6, 16); st_data = 32'h61;
    step();
    st_valid = 1'b0;
    step();
    dma_req = 1'b0;
    drains_seen = 0;
    drain_all(6);
    chk(drains_seen == 1, "R9 same-edge store kept", 64'(drains_seen), 1);

    // R4: request held past ack gives one ack only
    dma_req = 1'b1; dma_addr = mk(7, 0);
    repeat (5) step();
    dma_req = 1'b0;
    step(); step();

    // random mix
    for (int c = 0; c < 4000; c++) begin
      logic ack_seen;
      st_valid = ($urandom % 2) == 1;
      st_addr = mk($urandom % 4, $urandom % 64);
      st_data = $urandom;
      drain_ready = ($urandom % 4) != 0;
      ack_seen = dma_ack;
      if (dma_req && ack_seen) dma_req = 1'b0;
      else if (!dma_req && ph == 0 && ($urandom % 12) == 0) begin
        dma_req = 1'b1; dma_addr = mk($urandom % 4, $urandom % 64);
      end
      step();
    end
    st_valid = 1'b0;
    if (dma_req) begin step(); dma_req = 1'b0; end
    drain_all(40);
    chk(mq_n == 0, "R2 random queue empty", 64'(mq_n), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule